// File: doc/BRIEF.md
# History-Majority Branch Predictor

This block guesses the direction of a branch before it resolves. It keeps a small direct-mapped table. The low bits of the branch address select one entry. Each entry remembers the most recent resolved outcomes of the branches that map to it, together with a count of how many of those outcomes are real. The count saturates at the history depth.

A lookup supplies an address and a 2-bit branch-kind code, and the prediction comes back in the same cycle. When the selected entry holds a full history, the prediction is a majority vote over that history and the kind code plays no part. When the history is not yet full, a fixed per-kind rule decides: conditional branches are guessed not taken, and every other kind is guessed taken.

A separate update port reports the resolved outcome of a branch. That outcome is shifted into the matching entry on the next clock edge. A lookup in the same cycle as an update therefore still sees the history as it was before that update.

Top module: `brpred_majority`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) empties every entry, so afterwards every lookup follows the per-kind fixed rule.
- R2: The entry is selected by address bits [IDX_W-1:0] alone; two addresses that differ only in higher bits share one entry for both lookup and update.
- R3: When `up_valid` is high at a clock edge, `up_taken` is recorded as the newest outcome of the selected entry and that entry's oldest outcome is discarded; when `up_valid` is low, no entry changes.
- R4: Each entry counts its recorded outcomes up to HIST_N and no further; an entry with fewer than HIST_N outcomes predicts by the fixed rule.
- R5: An entry with HIST_N recorded outcomes predicts taken exactly when more than half of those outcomes were taken (with HIST_N = 3: two or more).
- R6: Under the fixed rule, kind code 1 (conditional) predicts not taken.
- R7: Under the fixed rule, kind codes 0 (unconditional), 2 (loop) and 3 (call/return) predict taken.
- R8: A lookup and an update to the same entry in the same cycle return the prediction formed from the history held before that update.
- R9: Once an entry's history is full, the kind code has no effect on its prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_addr | input | ADDR_W | Address of the branch being looked up |
| lk_kind | input | 2 | Branch kind: 0 unconditional, 1 conditional, 2 loop, 3 call/return |
| lk_taken | output | 1 | Prediction for the lookup, 1 = taken |
| up_valid | input | 1 | Record a resolved outcome this cycle |
| up_addr | input | ADDR_W | Address of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench targets the step from two recorded outcomes to three. A design that switched to voting too early, or that let the count wrap, would give history-based answers where the fixed rule should apply, or the reverse. Same-cycle lookup and update to one entry is driven repeatedly; a design that bypassed the new outcome into the lookup would change the answer one cycle too soon. Aliased addresses, idle update cycles that carry a live-looking outcome, and a history whose oldest bit alone decides the vote are also exercised. These catch designs that index with the wrong bits, that write without the valid signal, or that drop the newest outcome instead of the oldest.

// File: rtl/brp_pkg.sv
package brp_pkg;

  typedef enum logic [1:0] {
    BK_UNCOND  = 2'd0,
    BK_COND    = 2'd1,
    BK_LOOP    = 2'd2,
    BK_CALLRET = 2'd3
  } br_kind_e;

  // Fixed per-kind guess used while an entry's history is incomplete.
  function automatic logic static_guess(input br_kind_e kind);
    return (kind != BK_COND);
  endfunction

endpackage

// File: rtl/brp_entry.sv
module brp_entry #(
  parameter int HIST_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_taken,
  output logic [HIST_N-1:0] hist_o,
  output logic              full_o
);
  localparam int CNT_W = $clog2(HIST_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HIST_N);

  logic [CNT_W-1:0]  cnt_q;
  logic [HIST_N-1:0] hist_q;
  logic [HIST_N:0]   hist_ext;

  // Newest outcome enters at bit 0; the top bit falls off.
  assign hist_ext = {hist_q, wr_taken};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hist_q <= '0;
    end else if (wr_en) begin
      hist_q <= hist_ext[HIST_N-1:0];
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign full_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/brp_vote.sv
module brp_vote #(
  parameter int HIST_N = 3
) (
  input  logic [HIST_N-1:0] hist_i,
  output logic              taken_o
);
  localparam int SUM_W = $clog2(HIST_N + 1) + 1;

  logic [SUM_W-1:0] ones;

  always_comb begin
    ones = '0;
    for (int i = 0; i < HIST_N; i++) ones = ones + SUM_W'(hist_i[i]);
  end

  // Strict majority: twice the taken count exceeds the depth.
  assign taken_o = ({ones, 1'b0} > (SUM_W + 1)'(HIST_N));
endmodule

// File: rtl/brpred_majority.sv
module brpred_majority #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 4,
  parameter int HIST_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [1:0]        lk_kind,
  output logic              lk_taken,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken
);
  import brp_pkg::*;

  localparam int NENT = 1 << IDX_W;

  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  up_idx;
  logic [HIST_N-1:0] ent_hist [NENT];
  logic [NENT-1:0]   ent_full;
  logic [HIST_N-1:0] lk_hist;
  logic              lk_full;
  logic              lk_vote;
  logic              lk_static;
  logic              unused_addr_hi;

  assign lk_idx = lk_addr[IDX_W-1:0];
  assign up_idx = up_addr[IDX_W-1:0];
  assign unused_addr_hi = ^{lk_addr[ADDR_W-1:IDX_W], up_addr[ADDR_W-1:IDX_W]};

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    brp_entry #(.HIST_N(HIST_N)) u_ent (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (up_valid && (up_idx == IDX_W'(g))),
      .wr_taken (up_taken),
      .hist_o   (ent_hist[g]),
      .full_o   (ent_full[g])
    );
  end

  assign lk_hist = ent_hist[lk_idx];
  assign lk_full = ent_full[lk_idx];

  brp_vote #(.HIST_N(HIST_N)) u_vote (
    .hist_i  (lk_hist),
    .taken_o (lk_vote)
  );

  assign lk_static = static_guess(br_kind_e'(lk_kind));
  assign lk_taken  = lk_full ? lk_vote : lk_static;
endmodule

// File: rtl/brp_checker.sv
module brp_checker #(
  parameter int IDX_W  = 4,
  parameter int HIST_N = 3
) (
  input logic              clk,
  input logic              rst,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [1:0]        lk_kind,
  input logic              lk_taken,
  input logic              up_valid,
  input logic [IDX_W-1:0]  up_idx,
  input logic              up_taken,
  input logic [HIST_N-1:0] lk_hist,
  input logic              lk_full
);
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lk_full); // R1

  AST_STATIC_COND: assert property (@(posedge clk) disable iff (rst)
    (!lk_full && lk_kind == 2'd1) |-> !lk_taken); // R6

  AST_STATIC_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (!lk_full && lk_kind != 2'd1) |-> lk_taken); // R7

  AST_MAJORITY: assert property (@(posedge clk) disable iff (rst)
    lk_full |-> (lk_taken == (($countones(lk_hist) * 2) > HIST_N))); // R5

  AST_NEWEST_IN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(up_valid) && $past(up_idx) == lk_idx)
      |-> (lk_hist[0] == $past(up_taken))); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(lk_idx) && !($past(up_valid) && $past(up_idx) == lk_idx))
      |-> ($stable(lk_hist) && $stable(lk_full))); // R3
endmodule

bind brpred_majority brp_checker #(.IDX_W(IDX_W), .HIST_N(HIST_N)) u_brp_chk (
  .clk      (clk),
  .rst      (rst),
  .lk_idx   (lk_idx),
  .lk_kind  (lk_kind),
  .lk_taken (lk_taken),
  .up_valid (up_valid),
  .up_idx   (up_idx),
  .up_taken (up_taken),
  .lk_hist  (lk_hist),
  .lk_full  (lk_full)
);

// File: tb/tb_brpred_majority.sv
`timescale 1ns/1ps
module tb_brpred_majority;
  localparam int ADDR_W = 16;
  localparam int IDX_W  = 4;
  localparam int HIST_N = 3;
  localparam int NENT   = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [1:0]        lk_kind = 2'd0;
  logic              lk_taken;
  logic              up_valid = 1'b0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_taken = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference: per-entry queue of outcomes, newest at the back.
  int hist_q [NENT][$];

  always #10 clk = ~clk;

  brpred_majority #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HIST_N(HIST_N)) dut (
    .clk(clk), .rst(rst), .lk_addr(lk_addr), .lk_kind(lk_kind), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken)
  );

  function automatic int ent_of(input int addr);
    return addr % NENT;
  endfunction

  function automatic bit model_pred(input int addr, input int kind);
    int e = ent_of(addr);
    int t = 0;
    if (hist_q[e].size() < HIST_N) return (kind != 1);
    foreach (hist_q[e][i]) t += hist_q[e][i];
    return (2 * t > HIST_N);
  endfunction

  function automatic string auto_tag(input int addr, input int kind);
    if (hist_q[ent_of(addr)].size() < HIST_N) return (kind == 1) ? "R6" : "R7";
    return "R5";
  endfunction

  // One cycle: drive at the falling edge, compare, then commit the model at the rising edge.
  task automatic step(input int la, input int lk, input bit uv, input int ua,
                      input bit ut, input string tag);
    bit exp;
    @(negedge clk);
    lk_addr = ADDR_W'(la); lk_kind = 2'(lk);
    up_valid = uv; up_addr = ADDR_W'(ua); up_taken = ut;
    #2;
    exp = model_pred(la, lk);
    checks++;
    if (lk_taken !== exp) begin
      fails++;
      $display("FAIL %s: addr=%0d kind=%0d got=%b expected=%b", 
               (tag == "") ? auto_tag(la, lk) : tag, la, lk, lk_taken, exp);
    end
    @(posedge clk);
    if (rst) begin
      for (int e = 0; e < NENT; e++) hist_q[e].delete();
    end else if (uv) begin
      hist_q[ent_of(ua)].push_back(int'(ut));
      if (hist_q[ent_of(ua)].size() > HIST_N) void'(hist_q[ent_of(ua)].pop_front());
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, 0, 1'b0, 0, 1'b0, "R1");
    step(0, 0, 1'b0, 0, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: empty after reset, every kind follows the fixed rule (R6 / R7).
    for (int k = 0; k < 4; k++) step(3, k, 1'b0, 0, 1'b0, (k == 1) ? "R6" : "R7");

    // R8 / R4: fill entry 5 with T,N,T while looking it up as conditional.
    step(5, 1, 1'b1, 5, 1'b1, "R8");
    step(5, 1, 1'b1, 5, 1'b0, "R4");
    step(5, 1, 1'b1, 5, 1'b1, "R8");
    // R5 / R9: full history (T,N,T) votes taken even for a conditional.
    step(5, 1, 1'b0, 0, 1'b0, "R9");
    step(5, 0, 1'b0, 0, 1'b0, "R5");
    // R3: idle update port carrying a live-looking outcome changes nothing.
    step(5, 2, 1'b0, 5, 1'b0, "R3");
    step(5, 2, 1'b0, 5, 1'b0, "R3");
    // R3: oldest T drops, N enters: N,T,N -> not taken, even for kind 0 (R9).
    step(5, 0, 1'b1, 5, 1'b0, "R8");
    step(5, 0, 1'b0, 0, 1'b0, "R9");
    step(5, 3, 1'b0, 0, 1'b0, "R5");
    // R2: aliased addresses share entry 5, on lookup and update.
    step(5 + NENT, 2, 1'b0, 0, 1'b0, "R2");
    step(5 + 3 * NENT, 1, 1'b1, 5 + 2 * NENT, 1'b1, "R2");
    step(5, 1, 1'b1, 5 + 5 * NENT, 1'b1, "R2");
    step(5 + 7 * NENT, 1, 1'b0, 0, 1'b0, "R2");
    // R4: a saturated count stays full through many more updates.
    for (int i = 0; i < 10; i++) step(5, 1, 1'b1, 5, 1'b0, "R4");
    step(5, 0, 1'b0, 0, 1'b0, "R4");
    // Neighbour entry untouched by all of the above.
    step(6, 1, 1'b0, 0, 1'b0, "R3");

    // Random traffic over a few entries and aliases, compared every cycle.
    for (int i = 0; i < 400; i++) begin
      int la = $urandom_range(0, 3 * NENT - 1);
      int ua = (i % 3 == 0) ? la : $urandom_range(0, 3 * NENT - 1);
      step(la, $urandom_range(0, 3), 1'($urandom_range(0, 1)), ua,
           1'($urandom_range(0, 1)), "");
    end

    // R1: reset in mid-run empties the populated entries.
    do_reset();
    for (int e = 0; e < NENT; e++) step(e, 1, 1'b0, 0, 1'b0, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule